// File: doc/BRIEF.md
# Medium-Rate Infrared Transmit Framer

This block turns a stream of payload bytes into the serial bit sequence of a medium-rate infrared link. A frame opens with a programmable number of flag octets (never fewer than two). The payload bits follow, then a 16-bit frame check sequence computed over the payload, and then one closing flag. Inside the payload and the check sequence, a 0 is inserted after every run of five 1s, so a flag can never appear inside the frame body. The opening and closing flags are sent without any inserted bits.

A bit-timing generator supplies a one-cycle `bit_en` strobe per bit slot of the faster line rate. For the slower rate (half the faster one), `half_rate` makes the framer use only every second strobe. A byte source offers bytes over a valid/ready pair and marks the final byte of a frame with `s_last`. `busy` tells the host whether a frame is in progress. `rx_off` keeps the local receiver disabled from the first frame bit until the final bit has left the line.

Top module: `mir_tx_framer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tx_bit`, `busy`, `rx_off` and `s_ready` are all 0.
- R2: A frame starts on a bit tick that finds the framer idle with `s_valid` high. It opens with N flag octets, each sent as the bit sequence 0,1,1,1,1,1,1,0, with no inserted zeros.
- R3: Payload bytes are sent least significant bit first. A 0 is inserted after every fifth consecutive 1 in the payload and check sequence. The run count starts at 0 for each frame, carries across byte boundaries and is cleared by every 0 that is sent, inserted ones included.
- R4: After the byte marked by `s_last`, the framer sends the check sequence. It is computed with the reflected polynomial 0x8408 (x^16+x^12+x^5+1), starting from 0xFFFF, over the payload bits only. It is sent complemented, least significant bit first, so "123456789" yields 0x906E.
- R5: After the check sequence, including any zero inserted after its last bit, exactly one closing flag (0,1,1,1,1,1,1,0) is sent. On a tick while idle with no frame waiting, the line bit is 0.
- R6: `s_ready` rises in the cycle after the tick that sends the last opening-flag bit, or the last bit of a non-final byte including an inserted zero. It stays high until the byte is taken and is low at every other time.
- R7: Each bit tick puts one bit on `tx_bit`, visible in the following cycle, and `tx_bit` does not change between ticks. With `half_rate` low, every `bit_en` strobe is a tick. With `half_rate` high, only the even-numbered strobes counted since reset are ticks.
- R8: `busy` is high from the cycle after the starting tick up to the cycle after the tick that sends the final closing-flag bit, when it falls.
- R9: `rx_off` rises with `busy` and stays high through the final bit's slot. It falls in the cycle after the next tick, unless that tick starts another frame.
- R10: N equals `flag_cnt` as sampled at the starting tick, with the values 0 and 1 treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Byte offered; also requests a frame start while idle |
| s_last | input | 1 | Offered byte is the final byte of the frame |
| s_ready | output | 1 | Framer takes the offered byte at this edge |
| flag_cnt | input | 4 | Number of opening flags (minimum 2 applied) |
| half_rate | input | 1 | Use every second strobe (slower line rate) |
| bit_en | input | 1 | One-cycle bit-slot strobe from the timing generator |
| tx_bit | output | 1 | Serial line bit |
| busy | output | 1 | Frame in progress |
| rx_off | output | 1 | Receiver disable while the transmitter owns the line |

## Verification
The assertions take two things for granted about the inputs. First, `bit_en` strobes are at least two cycles apart. Second, once a frame has started, the source keeps `s_valid` high with the next byte ready, so each requested byte is taken before the next tick needs it. The stimulus keeps to both: it spaces strobes two to four cycles apart, and it loads a complete frame into its byte queue before that frame can start. Each byte is then offered at once and held until taken.

// File: rtl/mir_pkg.sv
`timescale 1ns/1ps
package mir_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPEN  = 3'd1,
    ST_DATA  = 3'd2,
    ST_FCS   = 3'd3,
    ST_CLOSE = 3'd4
  } tx_state_e;

  localparam int          FLAG_BITS     = 8;
  localparam logic [7:0]  FLAG_PAT      = 8'h7E;   // sent LSB first: 0,1,1,1,1,1,1,0
  localparam logic [15:0] CRC_INIT      = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
endpackage

// File: rtl/mir_rate_gate.sv
`timescale 1ns/1ps
module mir_rate_gate (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic half_rate,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else if (bit_en) phase_q <= ~phase_q;
  end

  assign tick = bit_en & (~half_rate | phase_q);

  AST_HALF_SKIP: assert property (@(posedge clk) disable iff (rst)
    (half_rate && tick) |=> !(half_rate && tick)); // R7
endmodule

// File: rtl/mir_crc16.sv
`timescale 1ns/1ps
module mir_crc16 #(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] crc_nx
);
  logic fb;

  always_comb begin
    fb     = crc_q[0] ^ din;
    crc_nx = (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= INIT;
    else if (en)      crc_q <= crc_nx;
  end
endmodule

// File: rtl/mir_run_count.sv
`timescale 1ns/1ps
module mir_run_count #(
  parameter int RUN_LEN = 5
)(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic full,
  output logic near
);
  localparam int CW = $clog2(RUN_LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= din ? cnt_q + 1'b1 : '0;
  end

  assign full = (cnt_q == CW'(RUN_LEN));
  assign near = (cnt_q == CW'(RUN_LEN - 1));

  AST_RUN_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(RUN_LEN)); // R3
  AST_NO_LONG_RUN: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |-> !full); // R3
endmodule

// File: rtl/mir_tx_framer.sv
`timescale 1ns/1ps
module mir_tx_framer #(
  parameter int BYTE_W    = 8,
  parameter int CRC_W     = 16,
  parameter int FLAG_W    = 4,
  parameter int RUN_LEN   = 5,
  parameter int MIN_FLAGS = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic [FLAG_W-1:0] flag_cnt,
  input  logic              half_rate,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              busy,
  output logic              rx_off
);
  import mir_pkg::*;

  localparam int SH_W = (CRC_W > BYTE_W) ? CRC_W : BYTE_W;
  localparam int CN_W = $clog2(SH_W + 1);
  localparam int FB_W = $clog2(FLAG_BITS);

  tx_state_e         st_q, st_d;
  logic [FLAG_W-1:0] flg_q, flg_d;
  logic [FB_W-1:0]   fbit_q, fbit_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [CN_W-1:0]   left_q, left_d;
  logic              have_q, have_d;
  logic              last_q, last_d;
  logic              rdy_q, rdy_d;
  logic              tx_q, tx_d;
  logic              rx_q, rx_d;

  logic              tick;
  logic              crc_clr, crc_en;
  logic [CRC_W-1:0]  crc_q, crc_nx;
  logic              run_clr, run_en, run_full, run_near;
  logic              cur_bit, unit_end, take;

  mir_rate_gate u_rate (
    .clk(clk), .rst(rst), .bit_en(bit_en), .half_rate(half_rate), .tick(tick)
  );

  mir_crc16 #(.CRC_W(CRC_W), .POLY(CRC_POLY_REFL[CRC_W-1:0]), .INIT(CRC_INIT[CRC_W-1:0])) u_crc (
    .clk(clk), .rst(rst), .clear(crc_clr), .en(crc_en), .din(sh_q[0]),
    .crc_q(crc_q), .crc_nx(crc_nx)
  );

  mir_run_count #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .clr(run_clr), .en(run_en), .din(sh_q[0]),
    .full(run_full), .near(run_near)
  );

  always_comb begin
    st_d     = st_q;
    flg_d    = flg_q;
    fbit_d   = fbit_q;
    sh_d     = sh_q;
    left_d   = left_q;
    have_d   = have_q;
    last_d   = last_q;
    rdy_d    = rdy_q;
    tx_d     = tx_q;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    run_clr  = 1'b0;
    run_en   = 1'b0;
    unit_end = 1'b0;
    cur_bit  = sh_q[0];
    take     = rdy_q & s_valid;

    if (take) begin
      sh_d   = SH_W'(s_data);
      left_d = CN_W'(BYTE_W);
      have_d = 1'b1;
      last_d = s_last;
      rdy_d  = 1'b0;
    end

    if (tick) begin
      case (st_q)
        ST_IDLE: begin
          tx_d = 1'b0;
          if (s_valid) begin
            st_d    = ST_OPEN;
            flg_d   = (flag_cnt < FLAG_W'(MIN_FLAGS)) ? FLAG_W'(MIN_FLAGS) : flag_cnt;
            tx_d    = FLAG_PAT[0];
            fbit_d  = FB_W'(1);
            crc_clr = 1'b1;
            run_clr = 1'b1;
          end
        end
        ST_OPEN, ST_CLOSE: begin
          tx_d = FLAG_PAT[fbit_q];
          if (fbit_q == FB_W'(FLAG_BITS - 1)) begin
            fbit_d = '0;
            if (st_q == ST_CLOSE) begin
              st_d = ST_IDLE;
            end else if (flg_q == FLAG_W'(1)) begin
              st_d  = ST_DATA;
              rdy_d = 1'b1;
            end else begin
              flg_d = flg_q - 1'b1;
            end
          end else begin
            fbit_d = fbit_q + 1'b1;
          end
        end
        ST_DATA, ST_FCS: begin
          if (run_full) begin
            tx_d    = 1'b0;
            run_clr = 1'b1;
            if (left_q == '0) unit_end = 1'b1;
          end else begin
            tx_d   = cur_bit;
            sh_d   = sh_q >> 1;
            left_d = left_q - 1'b1;
            run_en = 1'b1;
            crc_en = (st_q == ST_DATA);
            if (left_q == CN_W'(1) && !(cur_bit && run_near)) unit_end = 1'b1;
          end
          if (unit_end) begin
            if (st_q == ST_FCS) begin
              st_d   = ST_CLOSE;
              fbit_d = '0;
            end else if (last_q) begin
              st_d   = ST_FCS;
              sh_d   = SH_W'(~(run_full ? crc_q : crc_nx));
              left_d = CN_W'(CRC_W);
              have_d = 1'b0;
            end else begin
              have_d = 1'b0;
              rdy_d  = 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end

    if (st_q != ST_IDLE || st_d != ST_IDLE) rx_d = 1'b1;
    else if (tick)                          rx_d = 1'b0;
    else                                    rx_d = rx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      flg_q  <= '0;
      fbit_q <= '0;
      sh_q   <= '0;
      left_q <= '0;
      have_q <= 1'b0;
      last_q <= 1'b0;
      rdy_q  <= 1'b0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      flg_q  <= flg_d;
      fbit_q <= fbit_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      have_q <= have_d;
      last_q <= last_d;
      rdy_q  <= rdy_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign tx_bit  = tx_q;
  assign s_ready = rdy_q;
  assign rx_off  = rx_q;
  assign busy    = (st_q != ST_IDLE);

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && tick && !s_valid) |=> !tx_bit); // R5
  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && run_full && (st_q == ST_DATA || st_q == ST_FCS)) |=> !tx_bit); // R3
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tx_bit)); // R7
  AST_BUSY_GATES_RX: assert property (@(posedge clk) disable iff (rst)
    busy |-> rx_off); // R9
  AST_READY_WAIT: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (st_q == ST_DATA && !have_q)); // R6
  AST_FEED_IN_TIME: assert property (@(posedge clk) disable iff (rst)
    (tick && st_q == ST_DATA) |-> have_q); // R6
  AST_FLAG_FLOOR: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (flg_q >= FLAG_W'(MIN_FLAGS))); // R10
endmodule

// File: tb/mir_tx_framer_tb.sv
`timescale 1ns/1ps
module mir_tx_framer_tb_top;
  typedef logic [7:0] byte_q_t[$];
  typedef struct packed { logic b; logic rel; logic [3:0] tag; } elem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [3:0] flag_cnt = 4'd2;
  logic       half_rate = 1'b0;
  logic       bit_en = 1'b0;
  logic       tx_bit, busy, rx_off;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int gap = 3;
  int en_cnt = 0;
  logic rdy_seen = 1'b0;

  byte_q_t pay;
  byte_q_t frame_bytes;
  elem_t   stream[$];

  logic ph = 1'b0;
  logic m_idle = 1'b1;
  logic exp_tx = 1'b0, exp_busy = 1'b0, exp_rx = 1'b0, exp_rdy = 1'b0;
  logic [3:0] cur_tag = 4'd5;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  mir_tx_framer dut_i (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .flag_cnt(flag_cnt), .half_rate(half_rate), .bit_en(bit_en),
    .tx_bit(tx_bit), .busy(busy), .rx_off(rx_off)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd7:    return "R7";
      4'd10:   return "R10";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic x;
    x = c[0] ^ b;
    return x ? ((c >> 1) ^ 16'h8408) : (c >> 1);
  endfunction

  function automatic logic [15:0] fcs_of(input byte_q_t d);
    logic [15:0] c;
    c = 16'hFFFF;
    foreach (d[i]) for (int j = 0; j < 8; j++) c = crc_step(c, d[i][j]);
    return ~c;
  endfunction

  task automatic push_raw(input logic b, input logic r, input logic [3:0] t);
    elem_t e;
    e.b = b; e.rel = r; e.tag = t;
    stream.push_back(e);
  endtask

  task automatic build_stream();
    int n, ones;
    logic [15:0] f;
    elem_t e;
    stream.delete();
    n = (flag_cnt < 4'd2) ? 2 : int'(flag_cnt);
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++)
        push_raw(j != 0 && j != 7, k == n - 1 && j == 7, (flag_cnt < 4'd2) ? 4'd10 : 4'd2);
    ones = 0;
    for (int i = 0; i < frame_bytes.size(); i++) begin
      for (int j = 0; j < 8; j++) begin
        push_raw(frame_bytes[i][j], 1'b0, 4'd3);
        ones = frame_bytes[i][j] ? ones + 1 : 0;
        if (ones == 5) begin push_raw(1'b0, 1'b0, 4'd3); ones = 0; end
      end
      if (i != frame_bytes.size() - 1) begin
        e = stream.pop_back(); e.rel = 1'b1; stream.push_back(e);
      end
    end
    f = fcs_of(frame_bytes);
    for (int j = 0; j < 16; j++) begin
      push_raw(f[j], 1'b0, 4'd4);
      ones = f[j] ? ones + 1 : 0;
      if (ones == 5) begin push_raw(1'b0, 1'b0, 4'd4); ones = 0; end
    end
    for (int j = 0; j < 8; j++) push_raw(j != 0 && j != 7, 1'b0, 4'd5);
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    logic tk, was_idle;
    elem_t e;
    if (rst) begin
      ph = 1'b0; m_idle = 1'b1; exp_tx = 1'b0; exp_busy = 1'b0;
      exp_rx = 1'b0; exp_rdy = 1'b0; stream.delete(); cur_tag = 4'd5;
    end else begin
      if (rdy_seen && s_valid) begin
        exp_rdy = 1'b0;
        void'(pay.pop_front());
      end
      tk = bit_en && (!half_rate || ph);
      if (bit_en) ph = !ph;
      cur_tag = 4'd7;
      if (tk) begin
        was_idle = m_idle;
        cur_tag = 4'd5;
        if (m_idle) begin
          exp_tx = 1'b0;
          if (s_valid) begin build_stream(); m_idle = 1'b0; end
        end
        if (!m_idle) begin
          e = stream.pop_front();
          exp_tx = e.b;
          cur_tag = e.tag;
          if (e.rel) exp_rdy = 1'b1;
          if (stream.size() == 0) m_idle = 1'b1;
        end
        exp_rx = was_idle ? !m_idle : 1'b1;
      end
      exp_busy = !m_idle;
    end
  end

  // compare, then drive inputs, at each falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(tx_bit === exp_tx, tag_name(cur_tag), "tx_bit", tx_bit, exp_tx);
      chk(busy === exp_busy, "R8", "busy", busy, exp_busy);
      chk(rx_off === exp_rx, "R9", "rx_off", rx_off, exp_rx);
      chk(s_ready === exp_rdy, "R6", "s_ready", s_ready, exp_rdy);
    end
    rdy_seen = s_ready;
    en_cnt++;
    if (en_cnt >= gap) begin bit_en = 1'b1; en_cnt = 0; end
    else bit_en = 1'b0;
    s_valid = (pay.size() != 0);
    s_data  = (pay.size() != 0) ? pay[0] : 8'h00;
    s_last  = (pay.size() == 1);
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send_frame(input byte_q_t d, input logic [3:0] fc, input logic hr, input int g);
    while (pay.size() != 0) @(negedge clk);
    #1;
    flag_cnt = fc;
    half_rate = hr;
    gap = g;
    frame_bytes = d;
    pay = d;
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    byte_q_t d;
    logic [15:0] c;
    repeat (4) @(negedge clk);
    chk(tx_bit === 1'b0 && busy === 1'b0 && rx_off === 1'b0 && s_ready === 1'b0,
        "R1", "outputs in reset", {28'd0, tx_bit, busy, rx_off, s_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_bit === 1'b0 && busy === 1'b0 && rx_off === 1'b0 && s_ready === 1'b0,
        "R1", "outputs after reset", {28'd0, tx_bit, busy, rx_off, s_ready}, 0);

    // R4: check-sequence reference value
    d = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    c = fcs_of(d);
    chk(c == 16'h906E, "R4", "fcs of digits", c, 16'h906E);

    repeat (10) @(negedge clk);                           // idle ticks, line 0 (R5)
    send_frame('{8'hFF, 8'hFF, 8'h00}, 4'd2, 1'b0, 3);     // R3 long runs
    send_frame(d, 4'd0, 1'b1, 2);                          // R10 clamp, R7 half rate
    send_frame('{8'hF8, 8'h1F, 8'h7E}, 4'd5, 1'b0, 2);     // R3 stuff at byte end, R2
    send_frame('{8'h00}, 4'd1, 1'b0, 4);                   // R10, single byte
    send_frame('{8'h3E, 8'hFF, 8'hFF, 8'hFF}, 4'd3, 1'b1, 3); // back to back, R8 R9
    for (int f = 0; f < 4; f++) begin
      byte_q_t r;
      int len;
      lfsr = lfsr_next(lfsr);
      len = 1 + int'(lfsr[2:0] % 6);
      for (int i = 0; i < len; i++) begin
        lfsr = lfsr_next(lfsr);
        r.push_back(lfsr[7:0]);
      end
      send_frame(r, 4'(2 + f % 3), f[0], 2 + f % 3);
    end
    while (!(pay.size() == 0 && m_idle)) @(negedge clk);
    repeat (30) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule